// File: doc/BRIEF.md
# Descriptor DMA Channel Register Front End

This block is the register-side control plane of a multi-channel descriptor DMA. A host reaches it over a simple 32-bit register bus. Each channel gets its own 8 KiB address window. Inside that window sit five descriptor pointer registers, a configuration register, a command register, a stream-command register, an interrupt mask, a write-one-to-clear acknowledge, and read-only status, raw-interrupt and masked-interrupt views.

The block keeps a small state machine for each channel, with the states reset, stopped and running. It turns register writes into single-cycle strobes for the channel engines: load a data descriptor, load a context, start, continue, and restart. The engines report back through narrow inputs: interrupt events, an end-of-list event, the end-of-list flag of the current descriptor, and the result of a descriptor reload that follows a continue. Each channel drives one interrupt line. Moving the data itself is left to the engines.

Top module: `dma_regfile`

## Requirements
- R1: The channel is addressed by bus_addr bits above bit 12, and the register by bits 7:2. Register indices are: data pointer 0, saved descriptor 22, saved buffer 23, group 24, group-down 31, command 32, config 33, status 34, mask 35, acknowledge 36, raw 37, masked 38, stream command 39. Any other index reads zero. A channel number at or beyond NUM_CH reads zero, and writes to it have no effect.
- R2: The five pointer registers (indices 0, 22, 23, 24, 31) hold full 32-bit values. Each reads back what was written and drives the matching per-channel pointer output.
- R3: Config stores bits 1:0. Bit 0 means enabled and bit 1 means stopped. A config write with bit 1 set forces the stopped state. A config write with bit 0 clear forces the reset state, and this wins over bit 1. After reset every channel is in the reset state.
- R4: Status reads return the one-hot state code in bits 2:0 (reset 1, stopped 2, running 4) and the latched end-of-list flag in bit 5. All other status bits are zero.
- R5: Stream command stores bits 9:0 and reads them back. If written bit 8 or bit 6 is set, ld_data pulses. If, in addition, bit 5 is set, start pulses, the channel goes to running and its end-of-list latch clears. If written bit 9 is set, ld_ctx pulses.
- R6: A command write stores bit 0. It pulses cont only when all of the following hold: config is enabled and not stopped, the state is running, and desc_eol for that channel is high.
- R7: An eng_eol pulse sets the channel's end-of-list latch. A reload_done that follows a continue pulses restart only if reload_eol is low and the latch is set. A restart clears the latch. Any other reload_done leaves the state and the latch unchanged.
- R8: intr_set pulses OR into the raw interrupt bits. A write to acknowledge clears each raw bit written as one. A set in the same cycle as an acknowledge wins. The acknowledge register reads zero.
- R9: The masked register equals raw AND mask. irq for a channel is high exactly when any masked bit of that channel is set.
- R10: Any access whose bus_size is not a word (2) counts as illegal. An illegal read returns zero, an illegal write changes nothing, and either one sets bus_err, which stays set until reset.
- R11: Every read returns bus_rvalid with its data one cycle after the request. All strobes are high for exactly the one cycle after the triggering edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Sticky illegal-access flag |
| desc_eol | input | NUM_CH | Current descriptor end-of-list flag per channel |
| eng_eol | input | NUM_CH | Engine reached end of list |
| reload_done | input | NUM_CH | Descriptor reload after continue finished |
| reload_eol | input | NUM_CH | End-of-list flag of the reloaded descriptor |
| intr_set | input | NUM_CH x IRQ_W | Interrupt events per channel |
| irq | output | NUM_CH | Interrupt line per channel |
| ld_data | output | NUM_CH | Load data descriptor strobe |
| ld_ctx | output | NUM_CH | Load context strobe |
| start | output | NUM_CH | Start strobe |
| cont | output | NUM_CH | Continue (reload descriptor) strobe |
| restart | output | NUM_CH | Restart at next descriptor strobe |
| ptr_data | output | NUM_CH x 32 | Data pointer |
| ptr_desc | output | NUM_CH x 32 | Saved descriptor pointer |
| ptr_buf | output | NUM_CH x 32 | Saved buffer pointer |
| ptr_grp | output | NUM_CH x 32 | Group pointer |
| ptr_gdown | output | NUM_CH x 32 | Group-down pointer |

## Verification
The embedded properties check the following on every cycle: the state code stays one-hot, the acknowledge really clears the bits it names, and restart only follows a clean reload. They also check that start and continue strobes only appear in a running state, that bus_err never falls, and that read data valid trails its request by one cycle. The full continue handshake is shown only by the bench's scenarios. That covers a continue refused for each of its four conditions, a reload that still carries end-of-list, and a set racing an acknowledge. The same holds for address aliasing beyond the last channel and for illegal sizes leaving every register untouched.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    typedef enum logic [2:0] {
        CH_IDLE = 3'b001,
        CH_HALT = 3'b010,
        CH_RUN  = 3'b100
    } ch_state_e;

    localparam int REG_IDX_W = 6;

    localparam logic [REG_IDX_W-1:0] IDX_DPTR = 6'd0;
    localparam logic [REG_IDX_W-1:0] IDX_DESC = 6'd22;
    localparam logic [REG_IDX_W-1:0] IDX_BUF  = 6'd23;
    localparam logic [REG_IDX_W-1:0] IDX_GRP  = 6'd24;
    localparam logic [REG_IDX_W-1:0] IDX_GDN  = 6'd31;
    localparam logic [REG_IDX_W-1:0] IDX_CMD  = 6'd32;
    localparam logic [REG_IDX_W-1:0] IDX_CFG  = 6'd33;
    localparam logic [REG_IDX_W-1:0] IDX_STAT = 6'd34;
    localparam logic [REG_IDX_W-1:0] IDX_MASK = 6'd35;
    localparam logic [REG_IDX_W-1:0] IDX_ACK  = 6'd36;
    localparam logic [REG_IDX_W-1:0] IDX_RAW  = 6'd37;
    localparam logic [REG_IDX_W-1:0] IDX_MSKD = 6'd38;
    localparam logic [REG_IDX_W-1:0] IDX_SCMD = 6'd39;

    localparam int        SCMD_W     = 10;
    localparam logic [9:0] SC_LOAD_D = 10'h140;
    localparam logic [9:0] SC_BURST  = 10'h020;
    localparam logic [9:0] SC_LOAD_C = 10'h200;

    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam int         WIN_LSB = 13;

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int ADDR_W   = 16,
    parameter int CH_IDX_W = 2
) (
    input  logic                  valid_i,
    input  logic                  write_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [1:0]            size_i,
    output logic [CH_IDX_W-1:0]   ch_o,
    output logic [REG_IDX_W-1:0]  idx_o,
    output logic [NUM_CH-1:0]     wr_o,
    output logic                  rd_ok_o,
    output logic                  bad_o
);
    localparam int CH_FIELD_W = ADDR_W - WIN_LSB;

    logic [CH_FIELD_W-1:0] ch_field;
    logic                  in_range;
    logic                  word;
    logic                  unused_addr;

    assign ch_field    = addr_i[ADDR_W-1:WIN_LSB];
    assign in_range    = {1'b0, ch_field} < (CH_FIELD_W+1)'(NUM_CH);
    assign word        = (size_i == SZ_WORD);
    assign idx_o       = addr_i[7:2];
    assign ch_o        = CH_IDX_W'(ch_field);
    assign rd_ok_o     = valid_i && !write_i && word && in_range;
    assign bad_o       = valid_i && !word;
    assign unused_addr = ^{addr_i[WIN_LSB-1:8], addr_i[1:0]};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_wsel
        assign wr_o[g] = valid_i && write_i && word && in_range &&
                         (ch_field == CH_FIELD_W'(g));
    end

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
    import dmar_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [REG_IDX_W-1:0] idx_i,
    input  logic [31:0]          wdata_i,
    input  logic                 desc_eol_i,
    input  logic                 eng_eol_i,
    input  logic                 reload_done_i,
    input  logic                 reload_eol_i,
    input  logic [IRQ_W-1:0]     intr_set_i,
    output logic [31:0]          rdata_o,
    output logic                 irq_o,
    output logic                 ld_data_o,
    output logic                 ld_ctx_o,
    output logic                 start_o,
    output logic                 cont_o,
    output logic                 restart_o,
    output logic [31:0]          dptr_o,
    output logic [31:0]          desc_o,
    output logic [31:0]          buf_o,
    output logic [31:0]          grp_o,
    output logic [31:0]          gdn_o
);
    typedef struct packed {
        logic [31:0]       dptr;
        logic [31:0]       desc;
        logic [31:0]       bufp;
        logic [31:0]       grp;
        logic [31:0]       gdn;
        logic              cmd;
        logic [1:0]        cfg;
        logic [SCMD_W-1:0] scmd;
        logic [IRQ_W-1:0]  mask;
        logic [IRQ_W-1:0]  raw;
        ch_state_e         st;
        logic              eol;
        logic              pend;
        logic              ld_d;
        logic              ld_c;
        logic              start;
        logic              cont;
        logic              restart;
    } chan_t;

    chan_t q, d;
    logic [SCMD_W-1:0] wcmd;
    logic              can_cont;

    assign wcmd     = wdata_i[SCMD_W-1:0];
    assign can_cont = q.cfg[0] && !q.cfg[1] && (q.st == CH_RUN) && desc_eol_i;

    always_comb begin
        d         = q;
        d.ld_d    = 1'b0;
        d.ld_c    = 1'b0;
        d.start   = 1'b0;
        d.cont    = 1'b0;
        d.restart = 1'b0;
        d.raw     = q.raw | intr_set_i;

        if (eng_eol_i) begin
            d.eol = 1'b1;
        end

        if (reload_done_i && q.pend) begin
            d.pend = 1'b0;
            if (!reload_eol_i && q.eol) begin
                d.restart = 1'b1;
                d.eol     = 1'b0;
                d.st      = CH_RUN;
            end
        end

        if (wr_i) begin
            case (idx_i)
                IDX_DPTR: d.dptr = wdata_i;
                IDX_DESC: d.desc = wdata_i;
                IDX_BUF:  d.bufp = wdata_i;
                IDX_GRP:  d.grp  = wdata_i;
                IDX_GDN:  d.gdn  = wdata_i;
                IDX_CMD: begin
                    d.cmd = wdata_i[0];
                    if (can_cont) begin
                        d.cont = 1'b1;
                        d.pend = 1'b1;
                    end
                end
                IDX_CFG: begin
                    d.cfg = wdata_i[1:0];
                    if (wdata_i[1]) d.st = CH_HALT;
                    if (!wdata_i[0]) d.st = CH_IDLE;
                end
                IDX_MASK: d.mask = wdata_i[IRQ_W-1:0];
                IDX_ACK:  d.raw  = (q.raw & ~wdata_i[IRQ_W-1:0]) | intr_set_i;
                IDX_SCMD: begin
                    d.scmd = wcmd;
                    if (|(wcmd & SC_LOAD_D)) begin
                        d.ld_d = 1'b1;
                        if (|(wcmd & SC_BURST)) begin
                            d.start = 1'b1;
                            d.st    = CH_RUN;
                            d.eol   = 1'b0;
                        end
                    end
                    if (|(wcmd & SC_LOAD_C)) begin
                        d.ld_c = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= CH_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (idx_i)
            IDX_DPTR: rdata_o = q.dptr;
            IDX_DESC: rdata_o = q.desc;
            IDX_BUF:  rdata_o = q.bufp;
            IDX_GRP:  rdata_o = q.grp;
            IDX_GDN:  rdata_o = q.gdn;
            IDX_CMD:  rdata_o = {31'b0, q.cmd};
            IDX_CFG:  rdata_o = {30'b0, q.cfg};
            IDX_STAT: rdata_o = 32'({q.eol, 2'b00, q.st});
            IDX_MASK: rdata_o = 32'(q.mask);
            IDX_RAW:  rdata_o = 32'(q.raw);
            IDX_MSKD: rdata_o = 32'(q.raw & q.mask);
            IDX_SCMD: rdata_o = 32'(q.scmd);
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o     = |(q.raw & q.mask);
    assign ld_data_o = q.ld_d;
    assign ld_ctx_o  = q.ld_c;
    assign start_o   = q.start;
    assign cont_o    = q.cont;
    assign restart_o = q.restart;
    assign dptr_o    = q.dptr;
    assign desc_o    = q.desc;
    assign buf_o     = q.bufp;
    assign grp_o     = q.grp;
    assign gdn_o     = q.gdn;

    // R3
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.st) == 1);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && idx_i == IDX_ACK && intr_set_i == '0)
        |=> ((q.raw & $past(wdata_i[IRQ_W-1:0])) == '0));

    // R7
    restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.restart |-> $past(reload_done_i && !reload_eol_i));

    // R6
    cont_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cont |-> (q.st == CH_RUN));

    // R5
    start_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> (q.st == CH_RUN && !q.eol));

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmar_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int IRQ_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [1:0]                    bus_size,
    input  logic [31:0]                   bus_wdata,
    output logic                          bus_rvalid,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_err,
    input  logic [NUM_CH-1:0]             desc_eol,
    input  logic [NUM_CH-1:0]             eng_eol,
    input  logic [NUM_CH-1:0]             reload_done,
    input  logic [NUM_CH-1:0]             reload_eol,
    input  logic [NUM_CH-1:0][IRQ_W-1:0]  intr_set,
    output logic [NUM_CH-1:0]             irq,
    output logic [NUM_CH-1:0]             ld_data,
    output logic [NUM_CH-1:0]             ld_ctx,
    output logic [NUM_CH-1:0]             start,
    output logic [NUM_CH-1:0]             cont,
    output logic [NUM_CH-1:0]             restart,
    output logic [NUM_CH-1:0][31:0]       ptr_data,
    output logic [NUM_CH-1:0][31:0]       ptr_desc,
    output logic [NUM_CH-1:0][31:0]       ptr_buf,
    output logic [NUM_CH-1:0][31:0]       ptr_grp,
    output logic [NUM_CH-1:0][31:0]       ptr_gdown
);
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
        logic        err;
    } port_t;

    port_t q, d;

    logic [CH_IDX_W-1:0]      dec_ch;
    logic [REG_IDX_W-1:0]     dec_idx;
    logic [NUM_CH-1:0]        dec_wr;
    logic                     dec_rd_ok;
    logic                     dec_bad;
    logic [NUM_CH-1:0][31:0]  chan_rd;

    dmar_decode #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .CH_IDX_W (CH_IDX_W)
    ) u_dec (
        .valid_i (bus_valid),
        .write_i (bus_write),
        .addr_i  (bus_addr),
        .size_i  (bus_size),
        .ch_o    (dec_ch),
        .idx_o   (dec_idx),
        .wr_o    (dec_wr),
        .rd_ok_o (dec_rd_ok),
        .bad_o   (dec_bad)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dmar_chan #(.IRQ_W(IRQ_W)) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_i          (dec_wr[g]),
            .idx_i         (dec_idx),
            .wdata_i       (bus_wdata),
            .desc_eol_i    (desc_eol[g]),
            .eng_eol_i     (eng_eol[g]),
            .reload_done_i (reload_done[g]),
            .reload_eol_i  (reload_eol[g]),
            .intr_set_i    (intr_set[g]),
            .rdata_o       (chan_rd[g]),
            .irq_o         (irq[g]),
            .ld_data_o     (ld_data[g]),
            .ld_ctx_o      (ld_ctx[g]),
            .start_o       (start[g]),
            .cont_o        (cont[g]),
            .restart_o     (restart[g]),
            .dptr_o        (ptr_data[g]),
            .desc_o        (ptr_desc[g]),
            .buf_o         (ptr_buf[g]),
            .grp_o         (ptr_grp[g]),
            .gdn_o         (ptr_gdown[g])
        );
    end

    always_comb begin
        d        = q;
        d.rvalid = bus_valid && !bus_write;
        d.rdata  = dec_rd_ok ? chan_rd[dec_ch] : '0;
        if (dec_bad) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rvalid = q.rvalid;
    assign bus_rdata  = q.rdata;
    assign bus_err    = q.err;

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    // R11
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    // R10
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != SZ_WORD) |=> (bus_rdata == '0));

endmodule

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
    import dmar_pkg::*;

    localparam int NC = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic bus_rvalid, bus_err;
    logic [31:0] bus_rdata;
    logic [NC-1:0] desc_eol = '0, eng_eol = '0, reload_done = '0, reload_eol = '0;
    logic [NC-1:0][IW-1:0] intr_set = '0;
    logic [NC-1:0] irq, ld_data, ld_ctx, start, cont, restart;
    logic [NC-1:0][31:0] ptr_data, ptr_desc, ptr_buf, ptr_grp, ptr_gdown;

    always #4 clk = ~clk;

    dma_regfile #(.NUM_CH(NC), .ADDR_W(16), .IRQ_W(IW)) uut (.*);

    int checks = 0, fails = 0, cycles = 0;

    logic [2:0]    m_st   [NC];
    logic          m_eol  [NC];
    logic          m_pend [NC];
    logic [1:0]    m_cfg  [NC];
    logic          m_cmd  [NC];
    logic [9:0]    m_scmd [NC];
    logic [IW-1:0] m_mask [NC];
    logic [IW-1:0] m_raw  [NC];
    logic [31:0]   m_ptr  [NC][5];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_addr(input int ch, input logic [5:0] idx);
        return 16'((ch << 13) | (int'(idx) << 2));
    endfunction

    function automatic int pidx(input logic [5:0] idx);
        case (idx)
            IDX_DPTR: return 0;
            IDX_DESC: return 1;
            IDX_BUF:  return 2;
            IDX_GRP:  return 3;
            IDX_GDN:  return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int ch, input logic [5:0] idx);
        if (ch >= NC) return 32'h0;
        if (pidx(idx) >= 0) return m_ptr[ch][pidx(idx)];
        case (idx)
            IDX_CMD:  return {31'b0, m_cmd[ch]};
            IDX_CFG:  return {30'b0, m_cfg[ch]};
            IDX_STAT: return 32'({m_eol[ch], 2'b00, m_st[ch]});
            IDX_MASK: return 32'(m_mask[ch]);
            IDX_RAW:  return 32'(m_raw[ch]);
            IDX_MSKD: return 32'(m_raw[ch] & m_mask[ch]);
            IDX_SCMD: return 32'(m_scmd[ch]);
            default:  return 32'h0;
        endcase
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] v = '0;
        for (int c = 0; c < NC; c++) v[c] = |(m_raw[c] & m_mask[c]);
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_st[c] = 3'b001; m_eol[c] = 0; m_pend[c] = 0; m_cfg[c] = 0;
            m_cmd[c] = 0; m_scmd[c] = 0; m_mask[c] = 0; m_raw[c] = 0;
            for (int p = 0; p < 5; p++) m_ptr[c][p] = 0;
        end
    endtask

    task automatic bus(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        intr_set = '0;
        rd = bus_rdata;
    endtask

    // word write through the model; intr_set may be preloaded by caller
    task automatic mwrite(input int ch, input logic [5:0] idx, input logic [31:0] v);
        logic [31:0] dummy;
        logic [NC-1:0] e_ld = '0, e_lc = '0, e_st = '0, e_ct = '0;
        logic [NC-1:0][IW-1:0] setv = intr_set;
        if (ch < NC) begin
            if (idx == IDX_SCMD) begin
                e_ld[ch] = |(v[9:0] & 10'h140);
                e_st[ch] = e_ld[ch] && v[5];
                e_lc[ch] = v[9];
            end
            if (idx == IDX_CMD)
                e_ct[ch] = m_cfg[ch][0] && !m_cfg[ch][1] && m_st[ch] == 3'b100 && desc_eol[ch];
        end
        bus(1'b1, mk_addr(ch, idx), 2'd2, v, dummy);
        // R5 R6 R11
        chk("R5 R6 strobes", 32'({ld_data, ld_ctx, start, cont, restart}),
            32'({e_ld, e_lc, e_st, e_ct, {NC{1'b0}}}));
        if (ch < NC) begin
            if (pidx(idx) >= 0) m_ptr[ch][pidx(idx)] = v;
            case (idx)
                IDX_CMD: begin m_cmd[ch] = v[0]; if (e_ct[ch]) m_pend[ch] = 1; end
                IDX_CFG: begin
                    m_cfg[ch] = v[1:0];
                    if (v[1]) m_st[ch] = 3'b010;
                    if (!v[0]) m_st[ch] = 3'b001;
                end
                IDX_MASK: m_mask[ch] = v[IW-1:0];
                IDX_ACK:  m_raw[ch] = m_raw[ch] & ~v[IW-1:0];
                IDX_SCMD: begin
                    m_scmd[ch] = v[9:0];
                    if (e_st[ch]) begin m_st[ch] = 3'b100; m_eol[ch] = 0; end
                end
                default: ;
            endcase
        end
        for (int c = 0; c < NC; c++) m_raw[c] = m_raw[c] | setv[c];
    endtask

    task automatic mread(input int ch, input logic [5:0] idx, input string req);
        logic [31:0] rd;
        bus(1'b0, mk_addr(ch, idx), 2'd2, 32'h0, rd);
        chk("R11 rvalid", 32'(bus_rvalid), 32'h1);
        chk(req, rd, exp_rd(ch, idx));
    endtask

    task automatic pulse_intr(input int ch, input logic [IW-1:0] bits);
        @(negedge clk); intr_set[ch] = bits;
        @(negedge clk); intr_set = '0;
        m_raw[ch] = m_raw[ch] | bits;
    endtask

    task automatic pulse_eol(input int ch);
        @(negedge clk); eng_eol[ch] = 1'b1;
        @(negedge clk); eng_eol = '0;
        m_eol[ch] = 1'b1;
    endtask

    task automatic reload(input int ch, input logic e);
        logic er;
        er = m_pend[ch] && !e && m_eol[ch];
        @(negedge clk); reload_done[ch] = 1'b1; reload_eol[ch] = e;
        @(posedge clk);
        @(negedge clk); reload_done = '0; reload_eol = '0;
        // R7
        chk("R7 restart", 32'(restart), 32'(er) << ch);
        if (m_pend[ch]) begin
            m_pend[ch] = 0;
            if (er) begin m_eol[ch] = 0; m_st[ch] = 3'b100; end
        end
    endtask

    logic [5:0] idx_tab [14] = '{IDX_DPTR, IDX_DESC, IDX_BUF, IDX_GRP, IDX_GDN, IDX_CMD,
                                 IDX_CFG, IDX_STAT, IDX_MASK, IDX_ACK, IDX_RAW, IDX_MSKD,
                                 IDX_SCMD, 6'd5};

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 reset state
        mread(0, IDX_STAT, "R3 R4 reset status");
        chk("R9 reset irq", 32'(irq), 32'h0);
        chk("R10 reset err", 32'(bus_err), 32'h0);

        // R2 pointers and outputs
        mwrite(1, IDX_GDN, 32'hCAFE_0123);
        mread(1, IDX_GDN, "R2 group-down readback");
        chk("R2 pointer output", ptr_gdown[1], 32'hCAFE_0123);

        // R1 out-of-range channel and aliasing
        mwrite(5, IDX_DPTR, 32'h1234_5678);
        mread(5, IDX_DPTR, "R1 beyond last channel");
        mread(1, IDX_DPTR, "R1 other channel untouched");
        mread(0, 6'd10, "R1 unmapped index");

        // R10 illegal sizes
        mwrite(2, IDX_DPTR, 32'hAAAA_5555);
        bus(1'b1, mk_addr(2, IDX_DPTR), 2'd0, 32'h0000_0001, rd);
        chk("R10 err set", 32'(bus_err), 32'h1);
        mread(2, IDX_DPTR, "R10 write ignored");
        bus(1'b0, mk_addr(2, IDX_DPTR), 2'd1, 32'h0, rd);
        chk("R10 illegal read zero", rd, 32'h0);
        chk("R10 err sticky", 32'(bus_err), 32'h1);

        // R3 R5 R6 R7 continue handshake on channel 1
        mwrite(1, IDX_CFG, 32'h1);
        mread(1, IDX_STAT, "R3 enable keeps reset state");
        mwrite(1, IDX_SCMD, 32'h160);
        mread(1, IDX_STAT, "R5 started running");
        pulse_eol(1);
        mread(1, IDX_STAT, "R4 R7 eol latched");
        desc_eol[1] = 1'b0;
        mwrite(1, IDX_CMD, 32'h1);
        desc_eol[1] = 1'b1;
        mwrite(1, IDX_CMD, 32'h1);
        reload(1, 1'b1);
        mread(1, IDX_STAT, "R7 eol reload keeps parked");
        mwrite(1, IDX_CMD, 32'h1);
        reload(1, 1'b0);
        mread(1, IDX_STAT, "R7 restart clears eol");
        mwrite(1, IDX_CFG, 32'h3);
        mread(1, IDX_STAT, "R3 stopped");
        mwrite(1, IDX_CMD, 32'h1);
        mwrite(1, IDX_CFG, 32'h2);
        mread(1, IDX_STAT, "R3 disable wins over stop");
        mwrite(1, IDX_SCMD, 32'h200);
        mread(1, IDX_SCMD, "R5 stream readback");

        // R8 R9 acknowledge collision
        mwrite(2, IDX_MASK, 32'h6);
        pulse_intr(2, 4'b0110);
        chk("R9 irq raised", 32'(irq), 32'(exp_irq()));
        @(negedge clk);
        intr_set[2] = 4'b0010;
        mwrite(2, IDX_ACK, 32'h6);
        mread(2, IDX_RAW, "R8 set wins over ack");
        mread(2, IDX_ACK, "R8 ack reads zero");
        mread(2, IDX_MSKD, "R9 masked");
        chk("R9 irq after ack", 32'(irq), 32'(exp_irq()));

        // random mix
        for (int i = 0; i < 700; i++) begin
            int ch = int'($urandom % 5);
            int op = int'($urandom % 8);
            logic [5:0] idx = idx_tab[$urandom % 14];
            logic [31:0] v = $urandom;
            desc_eol = NC'($urandom);
            if (op < 4) begin
                if ($urandom % 3 == 0) v = v & 32'h0000_0363;
                mwrite(ch, idx, v);
            end else if (op < 6) begin
                mread(ch, idx, "R1 R2 R4 R8 random read");
            end else if (ch < NC) begin
                if (op == 6) pulse_intr(ch, IW'($urandom));
                else if ($urandom % 2 == 0) pulse_eol(ch);
                else reload(ch, 1'($urandom));
            end
            chk("R9 irq", 32'(irq), 32'(exp_irq()));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule